// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the device side of a page-organised serial flash with two page buffers. It listens to a mode-0 SPI link and turns command frames into self-timed internal operations. Bits on `si` are taken on each rising edge of `sck` while `cs_n` is low, most significant bit first. Every operation frame is 32 bits long: an 8-bit opcode, a 4-bit reserved field, an address field and a don't-care tail. Nothing starts while the frame is being clocked in. The decision is made once, on the clock where `cs_n` returns high.

Two operations exist. The first erases a group of eight consecutive pages. The second copies one main-memory page into buffer 1 or buffer 2. The memory array is not modelled. Each operation is stood in for by a cycle counter, and `busy` stays high for the configured number of cycles. A status-read command streams a status byte on `so`, whose top bit shows ready (1) or busy (0). The stream keeps tracking the live state while the master holds `sck` low.

The SPI pins are sampled by the system clock `clk`. `sck` must stay in each level for at least two `clk` cycles. Launch details are reported on `op_valid`, `op_kind`, `op_page` and `op_buf` for the storage behind this block.

Top module: `sflash_cmd_front`

## Requirements
- R1: After synchronous reset, `busy`, `so`, `op_valid`, `op_kind`, `op_page` and `op_buf` are all 0.
- R2: Frame bits are taken from `si` on the `clk` cycle in which `sck` is seen rising and `cs_n` is low, MSB first. The bit layout is:
  - opcode in frame bits 31..24;
  - reserved field in bits 23..20, whose value has no effect;
  - page address in bits 19..9;
  - don't-care bits in bits 8..0, whose value has no effect.
- R3: An erase frame uses opcode 0x50. Its block number sits in frame bits 19..12. At launch, `op_kind` = 1, `op_buf` = 0 and `op_page` = block number × 8 (the first of the eight erased pages). `busy` is high for exactly ERASE_CYCLES cycles, starting on the launch cycle.
- R4: A transfer frame uses opcode 0x53 (buffer 1, `op_buf` = 0) or 0x55 (buffer 2, `op_buf` = 1). At launch, `op_kind` = 2 and `op_page` = frame bits 19..9. `busy` is high for exactly XFER_CYCLES cycles.
- R5: An operation launches only on the `clk` edge where `cs_n` is first seen high after being low. At that edge `op_valid` pulses for one cycle. While `cs_n` stays low, a complete frame leaves `busy` and `op_valid` at 0.
- R6: A frame holding fewer than 32 bits when `cs_n` rises starts nothing.
- R7: A 32-bit frame whose opcode is none of 0x50, 0x53 or 0x55 starts nothing.
- R8: An operation frame that completes while `busy` is high starts nothing. The `op_*` outputs and the running busy period are left unchanged.
- R9: After the 8 bits of opcode 0xD7, `so` repeats a status byte MSB first for as long as `cs_n` stays low. Bit 7 of the byte is 1 when ready and 0 when busy, and bits 6..0 are 0. `so` changes only while `sck` is low, and it is 0 whenever `cs_n` is high. Status reads work while `busy` is high.
- R10: When `sck` is parked low with bit 7 on `so`, `so` follows the ready state. It goes from 0 to 1 one `clk` cycle after `busy` falls.
- R11: Bits clocked in after the 32nd bit of a frame are ignored. The operation is decoded from the first 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the SPI pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | SPI chip select, active low |
| si | input | 1 | SPI serial data into the device |
| so | output | 1 | SPI serial data out of the device (status stream) |
| busy | output | 1 | High while a self-timed operation runs |
| op_valid | output | 1 | One-cycle pulse when an operation is launched |
| op_kind | output | 2 | Kind of the last launched operation: 1 erase, 2 transfer |
| op_page | output | PAGE_W | First page of the last launched operation |
| op_buf | output | 1 | Target buffer of the last transfer: 0 buffer 1, 1 buffer 2 |

## Verification
A bit counter that is off by one shows up in two ways. A full frame can be ignored, or a short one can launch. Either is visible at the `op_valid` edge on the same cycle as the `cs_n` rise. A shift register that is misaligned gives a wrong `op_page` or `op_kind` on that cycle. A faulty countdown makes `busy` drop early or late, and the status bit seen on a parked `so` moves one cycle later. A wrong status index gives a misplaced ready bit within one byte of polling. Every one of these faults differs from the reference on a specific clock, so the bench catches each fault at the first cycle where it appears.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [1:0] {
    OPK_NONE  = 2'd0,
    OPK_ERASE = 2'd1,
    OPK_XFER  = 2'd2
  } opk_t;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sfc_shift.sv
module sfc_shift #(
  parameter int FRAME_BITS = 32,
  parameter int OPC_W      = 8,
  parameter int CNT_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sck,
  input  logic                  cs_n,
  input  logic                  si,
  output logic [FRAME_BITS-1:0] frame,
  output logic [CNT_W-1:0]      nbits,
  output logic                  sck_rise,
  output logic                  cs_rise,
  output logic                  head_done,
  output logic [OPC_W-1:0]      head_code
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] HEAD = CNT_W'(OPC_W - 1);

  logic sck_q;
  logic cs_q;

  assign sck_rise  = sck & ~sck_q;
  assign cs_rise   = cs_n & ~cs_q;
  assign head_code = {frame[OPC_W-2:0], si};
  assign head_done = sck_rise & ~cs_n & (nbits == HEAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      frame <= '0;
      nbits <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) begin
        frame <= '0;
        nbits <= '0;
      end else if (sck_rise && (nbits < FULL)) begin
        frame <= {frame[FRAME_BITS-2:0], si};
        nbits <= nbits + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfc_decode.sv
module sfc_decode
  import sfc_pkg::*;
#(
  parameter int          FRAME_BITS = 32,
  parameter int          OPC_W      = 8,
  parameter int          RSV_W      = 4,
  parameter int          PAGE_W     = 11,
  parameter int          GRP_W      = 3,
  parameter int          CNT_W      = 6,
  parameter logic [7:0]  ERASE_OP   = 8'h50,
  parameter logic [7:0]  XFER1_OP   = 8'h53,
  parameter logic [7:0]  XFER2_OP   = 8'h55
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_rise,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic [CNT_W-1:0]      nbits,
  input  logic                  busy,
  output logic                  launch,
  output logic                  launch_erase,
  output logic                  op_valid,
  output logic [1:0]            op_kind,
  output logic [PAGE_W-1:0]     op_page,
  output logic                  op_buf
);
  localparam logic [CNT_W-1:0] FULL   = CNT_W'(FRAME_BITS);
  localparam int               ADDR_H = FRAME_BITS - OPC_W - RSV_W - 1;
  localparam int               NOPS   = 3;
  localparam logic [NOPS*OPC_W-1:0] OPS =
    {OPC_W'(XFER2_OP), OPC_W'(XFER1_OP), OPC_W'(ERASE_OP)};

  logic [OPC_W-1:0]  opc;
  logic [PAGE_W-1:0] addr;
  logic [NOPS-1:0]   hit;
  logic [PAGE_W-1:0] page_n;
  logic              unused_bits;

  assign opc  = frame[FRAME_BITS-1 -: OPC_W];
  assign addr = frame[ADDR_H -: PAGE_W];
  assign unused_bits = ^{frame[FRAME_BITS-OPC_W-1 -: RSV_W], frame[ADDR_H-PAGE_W:0]};

  for (genvar i = 0; i < NOPS; i++) begin : g_hit
    assign hit[i] = (opc == OPS[i*OPC_W +: OPC_W]);
  end

  assign launch       = cs_rise && (nbits == FULL) && !busy && (|hit);
  assign launch_erase = hit[0];
  assign page_n       = hit[0] ? {addr[PAGE_W-1:GRP_W], GRP_W'(0)} : addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_valid <= 1'b0;
      op_kind  <= OPK_NONE;
      op_page  <= '0;
      op_buf   <= 1'b0;
    end else begin
      op_valid <= launch;
      if (launch) begin
        op_kind <= hit[0] ? OPK_ERASE : OPK_XFER;
        op_page <= page_n;
        op_buf  <= hit[2];
      end
    end
  end
endmodule

// File: rtl/sfc_timer.sv
module sfc_timer #(
  parameter int ERASE_CYCLES = 400,
  parameter int XFER_CYCLES  = 150,
  parameter int TMR_W        = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_erase,
  output logic busy
);
  localparam logic [TMR_W-1:0] ER_LOAD = TMR_W'(ERASE_CYCLES - 1);
  localparam logic [TMR_W-1:0] XF_LOAD = TMR_W'(XFER_CYCLES - 1);

  logic [TMR_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      remain <= load_erase ? ER_LOAD : XF_LOAD;
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/sfc_status.sv
module sfc_status #(
  parameter int             OPC_W     = 8,
  parameter int             STAT_W    = 8,
  parameter logic [7:0]     STAT_OP   = 8'hD7,
  parameter logic [STAT_W-2:0] STAT_FILL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             sck_rise,
  input  logic             head_done,
  input  logic [OPC_W-1:0] head_code,
  input  logic             busy,
  output logic             so
);
  localparam int                IDX_W = (STAT_W > 1) ? $clog2(STAT_W) : 1;
  localparam logic [IDX_W-1:0]  TOP   = IDX_W'(STAT_W - 1);

  logic [STAT_W-1:0] sbyte;
  logic              smode;
  logic [IDX_W-1:0]  idx;

  for (genvar i = 0; i < STAT_W; i++) begin : g_sbit
    if (i == STAT_W - 1) begin : g_ready
      assign sbyte[i] = ~busy;
    end else begin : g_fill
      assign sbyte[i] = STAT_FILL[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smode <= 1'b0;
      idx   <= TOP;
      so    <= 1'b0;
    end else begin
      if (cs_n) so <= 1'b0;
      else if (!sck) so <= smode ? sbyte[idx] : 1'b0;

      if (cs_n) begin
        smode <= 1'b0;
        idx   <= TOP;
      end else if (head_done && (head_code == OPC_W'(STAT_OP))) begin
        smode <= 1'b1;
        idx   <= TOP;
      end else if (sck_rise && smode) begin
        idx <= (idx == '0) ? TOP : idx - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sflash_cmd_front.sv
module sflash_cmd_front
  import sfc_pkg::*;
#(
  parameter int         FRAME_BITS   = 32,
  parameter int         OPC_W        = 8,
  parameter int         RSV_W        = 4,
  parameter int         PAGE_W       = 11,
  parameter int         GRP_W        = 3,
  parameter int         STAT_W       = 8,
  parameter logic [7:0] ERASE_OP     = 8'h50,
  parameter logic [7:0] XFER1_OP     = 8'h53,
  parameter logic [7:0] XFER2_OP     = 8'h55,
  parameter logic [7:0] STAT_OP      = 8'hD7,
  parameter int         ERASE_CYCLES = 400,
  parameter int         XFER_CYCLES  = 150
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  output logic              so,
  output logic              busy,
  output logic              op_valid,
  output logic [1:0]        op_kind,
  output logic [PAGE_W-1:0] op_page,
  output logic              op_buf
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam int TMR_W = $clog2(max_int(ERASE_CYCLES, XFER_CYCLES) + 1);

  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      nbits;
  logic                  sck_rise;
  logic                  cs_rise;
  logic                  head_done;
  logic [OPC_W-1:0]      head_code;
  logic                  launch;
  logic                  launch_erase;

  sfc_shift #(.FRAME_BITS(FRAME_BITS), .OPC_W(OPC_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si),
    .frame(frame), .nbits(nbits), .sck_rise(sck_rise), .cs_rise(cs_rise),
    .head_done(head_done), .head_code(head_code)
  );

  sfc_decode #(
    .FRAME_BITS(FRAME_BITS), .OPC_W(OPC_W), .RSV_W(RSV_W), .PAGE_W(PAGE_W),
    .GRP_W(GRP_W), .CNT_W(CNT_W), .ERASE_OP(ERASE_OP), .XFER1_OP(XFER1_OP),
    .XFER2_OP(XFER2_OP)
  ) u_dec (
    .clk(clk), .rst(rst), .cs_rise(cs_rise), .frame(frame), .nbits(nbits),
    .busy(busy), .launch(launch), .launch_erase(launch_erase),
    .op_valid(op_valid), .op_kind(op_kind), .op_page(op_page), .op_buf(op_buf)
  );

  sfc_timer #(.ERASE_CYCLES(ERASE_CYCLES), .XFER_CYCLES(XFER_CYCLES), .TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .load(launch), .load_erase(launch_erase), .busy(busy)
  );

  sfc_status #(.OPC_W(OPC_W), .STAT_W(STAT_W), .STAT_OP(STAT_OP)) u_stat (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sck_rise(sck_rise),
    .head_done(head_done), .head_code(head_code), .busy(busy), .so(so)
  );
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
  parameter int PAGE_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              so,
  input logic              busy,
  input logic              op_valid,
  input logic [1:0]        op_kind,
  input logic [PAGE_W-1:0] op_page,
  input logic              op_buf
);
  AST_BUSY_AT_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> busy); // R3
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> !op_valid); // R5
  AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> !$past(busy)); // R8
  AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (rst)
    !op_valid |-> ($stable(op_kind) && $stable(op_page) && $stable(op_buf))); // R8
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> (op_kind == 2'd1 || op_kind == 2'd2)); // R7
  AST_ERASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 2'd1) |-> (op_page[2:0] == 3'd0 && !op_buf)); // R3
  AST_SO_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> !so); // R9
endmodule

bind sflash_cmd_front sfc_checker #(.PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .so(so), .busy(busy), .op_valid(op_valid),
  .op_kind(op_kind), .op_page(op_page), .op_buf(op_buf)
);

// File: tb/sim_sflash_cmd_front.sv
`timescale 1ns/1ps
module sim_sflash_cmd_front;
  localparam int ER_CYC = 400;
  localparam int XF_CYC = 150;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  logic so, busy, op_valid, op_buf;
  logic [1:0] op_kind;
  logic [10:0] op_page;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sflash_cmd_front u0 (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .so(so), .busy(busy),
    .op_valid(op_valid), .op_kind(op_kind), .op_page(op_page), .op_buf(op_buf)
  );

  // behavioural reference model
  bit m_sck_q, m_cs_q, m_busy, m_smode, m_so, m_valid, m_buf;
  int m_rem, m_idx, m_kind, m_page;
  bit q[$];

  always @(posedge clk) begin
    if (rst) begin
      m_sck_q = 0; m_cs_q = 1; m_busy = 0; m_smode = 0; m_so = 0; m_valid = 0;
      m_buf = 0; m_rem = 0; m_idx = 7; m_kind = 0; m_page = 0; q.delete();
    end else begin
      bit rise, crise, go, old_busy;
      longint fr;
      int n, opc;
      rise = sck && !m_sck_q;
      crise = cs_n && !m_cs_q;
      n = q.size();
      fr = 0;
      foreach (q[i]) fr = fr * 2 + q[i];
      opc = int'((fr >> 24) & 255);
      go = crise && n == 32 && !m_busy && (opc == 'h50 || opc == 'h53 || opc == 'h55);
      old_busy = m_busy;
      if (cs_n) m_so = 0;
      else if (!sck) m_so = m_smode ? ((m_idx == 7) ? !old_busy : 1'b0) : 1'b0;
      if (cs_n) begin m_smode = 0; m_idx = 7; end
      else if (rise) begin
        if (m_smode) m_idx = (m_idx + 7) % 8;
        if (n == 7 && (((fr << 1) | longint'(si)) == 'hD7)) begin m_smode = 1; m_idx = 7; end
      end
      if (go) begin m_busy = 1; m_rem = ((opc == 'h50) ? ER_CYC : XF_CYC) - 1; end
      else if (m_busy) begin if (m_rem == 0) m_busy = 0; else m_rem--; end
      m_valid = go;
      if (go) begin
        m_kind = (opc == 'h50) ? 1 : 2;
        m_buf = (opc == 'h55);
        m_page = (opc == 'h50) ? int'(((fr >> 12) & 255) << 3) : int'((fr >> 9) & 2047);
      end
      if (cs_n) q.delete();
      else if (rise && n < 32) q.push_back(si);
      m_sck_q = sck; m_cs_q = cs_n;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (busy !== m_busy) begin errors++; $display("FAIL R3 busy actual %0b expected %0b", busy, m_busy); end
      checks++;
      if (so !== m_so) begin errors++; $display("FAIL R9 so actual %0b expected %0b", so, m_so); end
      checks++;
      if (op_valid !== m_valid) begin errors++; $display("FAIL R5 op_valid actual %0b expected %0b", op_valid, m_valid); end
      checks++;
      if (op_kind !== 2'(m_kind)) begin errors++; $display("FAIL R7 op_kind actual %0d expected %0d", op_kind, m_kind); end
      checks++;
      if (op_page !== 11'(m_page) || op_buf !== m_buf) begin
        errors++; $display("FAIL R4 page/buf actual %0h/%0b expected %0h/%0b", op_page, op_buf, m_page, m_buf);
      end
    end
  end

  // port observers
  int run = 0, last_run = 0, pulses = 0;
  always @(negedge clk) begin
    if (op_valid) pulses++;
    if (busy) run++;
    else if (run != 0) begin last_run = run; run = 0; end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual %0h expected %0h", tag, act, exp); end
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    @(negedge clk) si = b;
    repeat (2) @(negedge clk);
    seen = so;
    sck = 1'b1;
    repeat (3) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic cs_low();
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_bits(input logic [39:0] w, input int n);
    logic s;
    for (int i = 0; i < n; i++) clk_bit(w[39-i], s);
  endtask

  task automatic frame(input logic [39:0] w, input int n);
    cs_low(); send_bits(w, n); cs_high();
  endtask

  task automatic rd_byte(output logic [7:0] v);
    logic s;
    v = 8'h00;
    for (int i = 0; i < 8; i++) begin clk_bit(1'b0, s); v = {v[6:0], s}; end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [39:0] er_frame(input logic [7:0] blk);
    return {8'h50, 4'hA, blk, 12'hC3F, 8'h00};
  endfunction
  function automatic logic [39:0] xf_frame(input logic [7:0] opc, input logic [10:0] pg, input logic [7:0] tail);
    return {opc, 4'hF, pg, 9'h1AB, tail};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b0, b1;
    int p0;
    bit saw0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && so == 0 && op_valid == 0 && op_kind == 0 && op_page == 0 && op_buf == 0,
        "R1 reset outputs", {busy, so, op_valid, op_kind, op_page, op_buf}, 0);

    // R5: complete erase frame with chip select held low
    cs_low(); send_bits(er_frame(8'hA5), 32);
    repeat (10) @(negedge clk);
    chk(busy == 0 && pulses == 0, "R5 no launch before cs rise", busy, 0);
    cs_high();
    chk(busy == 1 && op_kind == 2'd1 && op_page == 11'h528 && op_buf == 0,
        "R3 erase launch", {op_kind, op_page}, {2'd1, 11'h528});
    wait_idle();
    chk(last_run == ER_CYC, "R3 erase busy length", last_run, ER_CYC);

    // R4/R2: transfers to both buffers, reserved and don't-care bits set
    frame(xf_frame(8'h53, 11'h5A3, 8'h00), 32);
    chk(op_kind == 2'd2 && op_page == 11'h5A3 && op_buf == 0, "R4 R2 buffer1 transfer",
        {op_kind, op_buf, op_page}, {2'd2, 1'b0, 11'h5A3});
    wait_idle();
    chk(last_run == XF_CYC, "R4 transfer busy length", last_run, XF_CYC);
    frame(xf_frame(8'h55, 11'h7FF, 8'h00), 32);
    chk(op_kind == 2'd2 && op_page == 11'h7FF && op_buf == 1, "R4 buffer2 transfer",
        {op_kind, op_buf, op_page}, {2'd2, 1'b1, 11'h7FF});
    wait_idle();

    // R6: short frame
    p0 = pulses;
    frame(er_frame(8'h11), 31);
    repeat (3) @(negedge clk);
    chk(pulses == p0 && busy == 0 && op_page == 11'h7FF, "R6 short frame ignored", pulses - p0, 0);

    // R7: unknown opcode
    frame(xf_frame(8'h52, 11'h123, 8'h00), 32);
    repeat (3) @(negedge clk);
    chk(pulses == p0 && busy == 0 && op_kind == 2'd2, "R7 unknown opcode ignored", pulses - p0, 0);

    // R8: command while busy
    frame(er_frame(8'h03), 32);
    frame(xf_frame(8'h53, 11'h0F0, 8'h00), 32);
    chk(pulses == p0 + 1 && op_kind == 2'd1 && op_page == 11'h018, "R8 busy command ignored",
        op_page, 11'h018);
    // R9: status byte while busy
    cs_low(); send_bits({8'hD7, 32'h0}, 8); rd_byte(b0); cs_high();
    chk(b0 == 8'h00, "R9 status while busy", b0, 8'h00);
    wait_idle();
    chk(last_run == ER_CYC, "R8 busy period not extended", last_run, ER_CYC);

    // R9: status stream when idle, two bytes
    cs_low(); send_bits({8'hD7, 32'h0}, 8); rd_byte(b0); rd_byte(b1); cs_high();
    chk(b0 == 8'h80 && b1 == 8'h80, "R9 status repeat idle", {b0, b1}, 16'h8080);
    chk(so == 0, "R9 so low with cs high", so, 0);

    // R10: parked polling
    frame(xf_frame(8'h55, 11'h2C4, 8'h00), 32);
    cs_low(); send_bits({8'hD7, 32'h0}, 8);
    repeat (3) @(negedge clk);
    saw0 = (so == 0);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(saw0 && so == 1, "R10 parked poll turns ready", {saw0, so}, 2'b11);
    cs_high();

    // R11: overlong frame
    frame(xf_frame(8'h55, 11'h1B6, 8'hFF), 40);
    chk(op_page == 11'h1B6 && op_buf == 1 && op_valid == 0 && busy == 1, "R11 extra bits ignored",
        op_page, 11'h1B6);
    wait_idle();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule